// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two 32-bit operands and a carry input, producing a 32-bit sum and a carry output. Instead of one long ripple chain, the word is cut into six segments whose widths grow from the bottom of the word upward and then shrink for the short top segment. Each segment except the lowest holds two ripple adders. One assumes an incoming carry of 0 and the other assumes 1. The true carry from the segment below then picks one sum and one carry-out through a 2:1 multiplexer.

Segment widths are chosen so that the carry selecting a segment's result reaches it no later than that segment's own candidate sums settle. The critical path is therefore roughly the lowest segment's ripple plus one multiplexer per boundary, not 32 full-adder delays. The combined result is captured in an output register with a synchronous active-low reset, so that timing can be measured from register to register.

Top module: `sqrt_csel_adder`

## Requirements
- R1: One clock edge after inputs are sampled with reset released, {c_out, sum_out} equals the 33-bit value a_in + b_in + c_in.
- R2: While rst_n is low at a rising edge, sum_out and c_out become 0 at that edge.
- R3: The segments cover bits [3:0], [8:4], [14:9], [21:15], [29:22] and [31:30]. The carry entering each segment's lowest bit (4, 9, 15, 22, 30) equals the true carry out of all lower bits added with c_in.
- R4: In every segment above the lowest, the candidate (carry, sum) computed with carry-in 1 equals the candidate computed with carry-in 0 plus one.
- R5: In every segment above the lowest, a carry-out from the carry-in-0 candidate implies a carry-out from the carry-in-1 candidate.
- R6: All-ones operands with c_in = 1 give the correct wrap: 0xFFFFFFFF + 0 + 1 gives sum 0 with c_out 1, and 0xFFFFFFFF + 0xFFFFFFFF + 1 gives sum 0xFFFFFFFF with c_out 1.
- R7: c_out is 1 exactly when a_in + b_in + c_in is at least 2^32. It is the selected carry-out of the top segment.
- R8: A carry generated just below any segment boundary, with all bits above it propagating, travels through every higher segment to c_out.
- R9: With both operands zero, c_in alone sets sum_out to 1 and leaves c_out at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand |
| c_in | input | 1 | Carry input |
| sum_out | output | 32 | Registered sum |
| c_out | output | 1 | Registered carry output |

## Verification
The clocked assertions assume that a_in, b_in and c_in hold known, settled values at each rising edge once reset is released. Any X on an operand would make the segment and boundary comparisons meaningless. The stimulus therefore drives every input to a defined value from time zero and changes the inputs only on falling edges, so each rising edge sees a stable, fully propagated vector.

// File: rtl/csel_pkg.sv
// Segment layout for the carry-select adder.
// Assumes segment widths are positive. The layout total defines the word width.
package csel_pkg;

    localparam int unsigned NSEG = 6;

    // Width of segment i, lowest first.
    function automatic int unsigned seg_w(input int unsigned i);
        case (i)
            0:       return 4;
            1:       return 5;
            2:       return 6;
            3:       return 7;
            4:       return 8;
            default: return 2;
        endcase
    endfunction

    // Index of the lowest bit of segment i (i == NSEG gives the total width).
    function automatic int unsigned seg_lo(input int unsigned i);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < i; k++) acc += seg_w(k);
        return acc;
    endfunction

    localparam int unsigned SUM_W = seg_lo(NSEG);

endpackage

// File: rtl/csa_ripple.sv
// Plain ripple-carry adder of W bits.
// Assumes nothing about its inputs. The result is purely combinational.
module csa_ripple #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] c;

    // Seed the chain with the incoming carry.
    assign c[0] = ci;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            // One full-adder cell per bit.
            assign s[i]   = a[i] ^ b[i] ^ c[i];
            assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
        end
    endgenerate

    // Carry leaving the top bit.
    assign co = c[W];

endmodule

// File: rtl/csa_segment.sv
// One segment of the carry-select adder.
// With DUAL set, it precomputes results for carry-in 0 and 1 and selects with ci.
// Without it, the segment is a single ripple adder fed directly by ci.
// clk and rst_n serve only the local assertions.
module csa_segment #(
    parameter int unsigned W    = 4,
    parameter bit          DUAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    generate
        if (DUAL) begin : g_dual
            logic [W-1:0] s_zero, s_one;
            logic         co_zero, co_one;

            csa_ripple #(.W(W)) u_zero (
                .a(a), .b(b), .ci(1'b0), .s(s_zero), .co(co_zero)
            );
            csa_ripple #(.W(W)) u_one (
                .a(a), .b(b), .ci(1'b1), .s(s_one), .co(co_one)
            );

            // Select sum and carry-out with the true incoming carry.
            always_comb begin
                s  = ci ? s_one  : s_zero;
                co = ci ? co_one : co_zero;
            end

            AST_CAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                {co_one, s_one} == ({co_zero, s_zero} + (W+1)'(1)));  // R4
            AST_CAND_MONO: assert property (@(posedge clk) disable iff (!rst_n)
                co_zero |-> co_one);  // R5
        end else begin : g_single
            csa_ripple #(.W(W)) u_only (
                .a(a), .b(b), .ci(ci), .s(s), .co(co)
            );

            AST_BASE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
                {co, s} == ({1'b0, a} + {1'b0, b} + (W+1)'(ci)));  // R3
        end
    endgenerate

endmodule

// File: rtl/csa_out_reg.sv
// Output register with synchronous active-low reset.
// Assumes d is settled at each rising edge.
module csa_out_reg #(
    parameter int unsigned W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the adder result, or clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0));  // R2

endmodule

// File: rtl/sqrt_csel_adder.sv
// Square-root carry-select adder with a registered result.
// Segment widths come from csel_pkg. The lowest segment ripples from c_in, and
// every higher segment selects its precomputed result with the carry below.
// Assumes the inputs are known and stable at each rising edge.
module sqrt_csel_adder
    import csel_pkg::*;
#(
    parameter int unsigned WIDTH = SUM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);

    localparam int unsigned RES_W = WIDTH + 1;

    logic [NSEG:0]    seg_c;
    logic [WIDTH-1:0] sum_c;
    logic [RES_W-1:0] res_q;

    // The true carry enters the lowest segment.
    assign seg_c[0] = c_in;

    genvar g;
    generate
        for (g = 0; g < NSEG; g++) begin : g_seg
            localparam int unsigned LO = seg_lo(g);
            localparam int unsigned SW = seg_w(g);

            csa_segment #(.W(SW), .DUAL(g != 0)) u_seg (
                .clk   (clk),
                .rst_n (rst_n),
                .a     (a_in[LO+SW-1:LO]),
                .b     (b_in[LO+SW-1:LO]),
                .ci    (seg_c[g]),
                .s     (sum_c[LO+SW-1:LO]),
                .co    (seg_c[g+1])
            );
        end

        for (g = 1; g <= NSEG; g++) begin : g_bnd
            localparam int unsigned BL = seg_lo(g);
            AST_BOUNDARY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
                {{BL{1'b0}}, seg_c[g]} ==
                (({1'b0, a_in[BL-1:0]} + {1'b0, b_in[BL-1:0]} + {{BL{1'b0}}, c_in}) >> BL));  // R3
        end
    endgenerate

    csa_out_reg #(.W(RES_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({seg_c[NSEG], sum_c}),
        .q     (res_q)
    );

    // Split the registered word into ports.
    assign sum_out = res_q[WIDTH-1:0];
    assign c_out   = res_q[WIDTH];

    AST_SUM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({c_out, sum_out} ==
        $past({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in})));  // R1
    AST_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (c_out == $past((({1'b0, a_in} + {1'b0, b_in} +
        {{WIDTH{1'b0}}, c_in}) >> WIDTH) != '0)));  // R7

endmodule

// File: tb/tb_sqrt_csel_adder.sv
module tb_sqrt_csel_adder;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    typedef struct {
        logic [W:0] exp;
        string      tag;
    } sb_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         c_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         c_out;

    sb_item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sqrt_csel_adder dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sum_out(sum_out), .c_out(c_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Driver: present a vector on a falling edge and queue its expected result.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci, input string tag);
        sb_item_t it;
        @(negedge clk);
        a_in = a;
        b_in = b;
        c_in = ci;
        it.exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: after each rising edge, compare the result against the oldest entry.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                checks++;
                if ({c_out, sum_out} !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", it.tag, {c_out, sum_out}, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int bnd[6] = '{4, 9, 15, 22, 30, 32};

        // R2: reset clears the outputs even with live operands.
        a_in = 32'h1234_5678;
        b_in = 32'hFFFF_0000;
        c_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({c_out, sum_out} !== 33'h0) begin
            fails++;
            $display("FAIL R2: got %h expected %h", {c_out, sum_out}, 33'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(32'h0, 32'h0, 1'b1, "R9");
        drive(32'h0, 32'h0, 1'b0, "R9");
        drive(32'hFFFF_FFFF, 32'h0, 1'b1, "R6");
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R6");
        drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R7");
        drive(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, "R7");
        drive(32'h7FFF_FFFF, 32'h0000_0000, 1'b0, "R7");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R1");
        drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, "R1");
        drive(32'h0000_01F0, 32'h0000_0010, 1'b0, "R4/R5");
        drive(32'h3FFF_8000, 32'h0000_8000, 1'b1, "R4/R5");

        // R3: carry into each segment boundary from the bits below.
        foreach (bnd[i]) begin
            logic [W-1:0] lowmask;
            lowmask = W'((33'd1 << bnd[i]) - 33'd1);
            drive(lowmask, 32'h0, 1'b1, "R3");
            drive(lowmask, 32'h1, 1'b0, "R3");
        end

        // R8: carry generated below each boundary ripples to the top.
        foreach (bnd[i]) begin
            logic [W-1:0] gen_bit;
            gen_bit = W'(33'd1 << (bnd[i] - 1));
            drive(32'hFFFF_FFFF ^ gen_bit, gen_bit << 0, 1'b1, "R8");
            drive(~gen_bit | gen_bit, gen_bit, 1'b0, "R8");
        end

        // R1: random vectors.
        for (int n = 0; n < 300; n++) begin
            drive($urandom, $urandom, 1'($urandom % 2), "R1");
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule